// File: doc/BRIEF.md
# Differential Pulse-Rate to Code Converter

This block turns two pulse trains into one signed number. One train carries the rate from a converter that handles positive inputs. The other carries the rate from a converter that handles negative inputs. With zero input, both trains idle at the same nominal rate. Over each synchronization interval the block counts the rising edges on each train. At the next sync pulse it publishes the scaled difference of the two counts, a sign flag and an overflow flag.

Both trains idle at the same rate. Any zero drift that the two converters share therefore adds the same number of edges to both counts, and the subtraction removes it. A constant phase offset between the trains moves the result by at most one count. The published result stays on the output until the next sync pulse. The interval counters restart at that same sync pulse.

The pulse inputs are asynchronous to the clock and pass through a synchronizer chain. The sync input is a one-cycle strobe in the clock domain. The counter width, the scale constant and the synchronizer depth are all parameters.

Top module: `diff_freq_to_code`

## Requirements
- R1: After reset, `code_o`, `sign_o` and `ovf_o` are all 0.
- R2: Each low-to-high transition on `pos_pulse_i` adds one to the positive count. Each low-to-high transition on `neg_pulse_i` adds one to the negative count. A pulse held high for many cycles counts once.
- R3: On a clock edge where `sync_i` is 1, `code_o` takes the value SCALE·(Npos − Nneg). The value is two's complement and OUT_W bits wide, where OUT_W = CNT_W + clog2(SCALE+1) + 1.
- R4: On the same edge, `sign_o` becomes 1 exactly when Nneg > Npos. It becomes 0 when the two counts are equal.
- R5: `code_o`, `sign_o` and `ovf_o` change only on an edge where `sync_i` is 1. Between sync pulses they hold their values.
- R6: Both counts restart from zero after each sync edge. The next result reflects only edges detected after that sync edge.
- R7: An edge whose detection falls on the sync clock edge itself is counted into the new interval, not into the interval being closed.
- R8: Each count saturates at 2^CNT_W − 1. If an edge arrives at a saturated count, `ovf_o` is 1 in the result published at the end of that interval. Otherwise `ovf_o` is 0 in that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pos_pulse_i | input | 1 | Pulse train from the positive-polarity converter (asynchronous) |
| neg_pulse_i | input | 1 | Pulse train from the negative-polarity converter (asynchronous) |
| sync_i | input | 1 | One-cycle interval strobe, synchronous to clk |
| code_o | output | OUT_W | Scaled signed difference of the counts, held between syncs |
| sign_o | output | 1 | 1 when the negative count exceeds the positive count |
| ovf_o | output | 1 | A count saturated during the published interval |

## Verification
The bench sweeps every pair of counts from 0 to 15 with a small counter and a scale of 3. This exposes errors in scaling, in sign extension and in the sign flag at equal counts; a wrong design would publish a wrong value or flip the sign at zero. It checks that the outputs stay unchanged while pulses arrive mid-interval; a design that updated continuously would show partial counts. It places an edge exactly on the sync edge; a design that counted that edge into the closing interval would publish one count too many there and one count too few in the next interval. It also drives a count past saturation, followed by a clean interval; a counter that wrapped would publish a small code, and a flag that never cleared would stay set.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
   // width of the signed scaled difference
   function automatic int unsigned code_width(input int unsigned cnt_w, input int unsigned scale);
      return cnt_w + $clog2(scale + 1) + 1;
   endfunction

   typedef enum logic [0:0] {
      CH_POS = 1'b0,
      CH_NEG = 1'b1
   } chan_e;
endpackage

// File: rtl/dfc_edge_sync.sv
module dfc_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dfc_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;

   // R2: a detected rise lasts a single cycle
   p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/dfc_sat_counter.sv
module dfc_sat_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] count_o,
   output logic             sat_hit_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             hit_q;
   logic             at_max;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("dfc_sat_counter: CNT_W must be at least 2");
      end
   endgenerate

   assign at_max = (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hit_q <= 1'b0;
      end else if (restart_i) begin
         // an edge on the restart cycle opens the new interval
         cnt_q <= {{(CNT_W-1){1'b0}}, inc_i};
         hit_q <= 1'b0;
      end else if (inc_i) begin
         if (at_max) hit_q <= 1'b1;
         else        cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count_o   = cnt_q;
   assign sat_hit_o = hit_q;

   // R2: outside a restart the count moves by at most one
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !restart_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
   // R6: after a restart the count holds at most the coincident edge
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1});
   // R8: an overflow mark only exists on a full count
   p_hit_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |-> at_max);
endmodule

// File: rtl/dfc_result_reg.sv
module dfc_result_reg #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned SCALE = 1,
   parameter int unsigned OUT_W = dfc_pkg::code_width(CNT_W, SCALE)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic [CNT_W-1:0]        pos_cnt_i,
   input  logic [CNT_W-1:0]        neg_cnt_i,
   input  logic                    ovf_i,
   output logic signed [OUT_W-1:0] code_o,
   output logic                    sign_o,
   output logic                    ovf_o
);
   localparam int unsigned PAD = OUT_W - CNT_W;
   localparam logic signed [OUT_W-1:0] SCALE_V = OUT_W'(SCALE);

   logic signed [OUT_W-1:0] diff_w;
   logic signed [OUT_W-1:0] scaled_w;
   logic                    neg_larger;

   generate
      if (SCALE < 1) begin : g_bad_scale
         $error("dfc_result_reg: SCALE must be at least 1");
      end
   endgenerate

   always_comb begin
      diff_w     = $signed({{PAD{1'b0}}, pos_cnt_i}) - $signed({{PAD{1'b0}}, neg_cnt_i});
      scaled_w   = diff_w * SCALE_V;
      neg_larger = (neg_cnt_i > pos_cnt_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= '0;
         sign_o <= 1'b0;
         ovf_o  <= 1'b0;
      end else if (load_i) begin
         code_o <= scaled_w;
         sign_o <= neg_larger;
         ovf_o  <= ovf_i;
      end
   end

   // R5: the published result holds between loads
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(code_o) && $stable(sign_o) && $stable(ovf_o));
   // R4: the compare-based flag agrees with the sign of the arithmetic code
   p_sign_agrees_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sign_o == code_o[OUT_W-1]);
endmodule

// File: rtl/diff_freq_to_code.sv
module diff_freq_to_code #(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SCALE       = 1,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned OUT_W      = dfc_pkg::code_width(CNT_W, SCALE)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pos_pulse_i,
   input  logic                    neg_pulse_i,
   input  logic                    sync_i,
   output logic signed [OUT_W-1:0] code_o,
   output logic                    sign_o,
   output logic                    ovf_o
);
   localparam int unsigned NCH = 2;

   logic [NCH-1:0]   pulse_w;
   logic [NCH-1:0]   rise_w;
   logic [NCH-1:0]   hit_w;
   logic [CNT_W-1:0] cnt_w [NCH];

   assign pulse_w[dfc_pkg::CH_POS] = pos_pulse_i;
   assign pulse_w[dfc_pkg::CH_NEG] = neg_pulse_i;

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
         dfc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (pulse_w[ch]),
            .rise_o  (rise_w[ch])
         );
         dfc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (sync_i),
            .inc_i     (rise_w[ch]),
            .count_o   (cnt_w[ch]),
            .sat_hit_o (hit_w[ch])
         );
      end
   endgenerate

   dfc_result_reg #(.CNT_W(CNT_W), .SCALE(SCALE), .OUT_W(OUT_W)) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (sync_i),
      .pos_cnt_i (cnt_w[dfc_pkg::CH_POS]),
      .neg_cnt_i (cnt_w[dfc_pkg::CH_NEG]),
      .ovf_i     (|hit_w),
      .code_o    (code_o),
      .sign_o    (sign_o),
      .ovf_o     (ovf_o)
   );

   // R8: the flag is published only with a full count behind it
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && !(|hit_w)) |=> !ovf_o);
endmodule

// File: tb/sim_diff_freq_to_code.sv
module sim_diff_freq_to_code;
   localparam int unsigned CW = 4;
   localparam int unsigned K  = 3;
   localparam int unsigned OW = dfc_pkg::code_width(CW, K);
   localparam int MAXC = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pos = 1'b0, neg = 1'b0, sync = 1'b0;
   logic signed [OW-1:0] code;
   logic sgn, ovf;
   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   diff_freq_to_code #(.CNT_W(CW), .SCALE(K), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .pos_pulse_i(pos), .neg_pulse_i(neg),
      .sync_i(sync), .code_o(code), .sign_o(sgn), .ovf_o(ovf));

   task automatic chk(input string req, input int got, input int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s got=%0d expected=%0d", req, got, exp);
      end
   endtask

   task automatic close_interval();
      sync = 1'b1;
      @(negedge clk);
      sync = 1'b0;
   endtask

   // sends np/nn pulses, checks hold mid-burst, syncs, checks result
   task automatic run_interval(input int np, input int nn, input int prev_code,
                               input string tag);
      int m;
      int sat_p, sat_n, exp_ovf;
      m = (np > nn) ? np : nn;
      for (int i = 0; i < m; i++) begin
         pos = (i < np); neg = (i < nn);
         repeat (2) @(negedge clk);
         pos = 1'b0; neg = 1'b0;
         repeat (2) @(negedge clk);
      end
      if (m > 0) chk("R5 hold mid-interval", int'(code), prev_code);
      repeat (4) @(negedge clk);
      close_interval();
      sat_p = (np > MAXC) ? MAXC : np;
      sat_n = (nn > MAXC) ? MAXC : nn;
      exp_ovf = (np > MAXC || nn > MAXC) ? 1 : 0;
      chk({"R3 code ", tag}, int'(code), int'(K) * (sat_p - sat_n));
      chk({"R4 sign ", tag}, int'(sgn), (sat_n > sat_p) ? 1 : 0);
      chk({"R8 ovf ", tag}, int'(ovf), exp_ovf);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired got=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int prev;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 code", int'(code), 0);
      chk("R1 sign", int'(sgn), 0);
      chk("R1 ovf", int'(ovf), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 R4 R6: sweep all count pairs; each interval starts from zero
      prev = 0;
      for (int a = 0; a <= MAXC; a++) begin
         for (int b = 0; b <= MAXC; b++) begin
            run_interval(a, b, prev, "sweep");
            prev = int'(K) * (a - b);
         end
      end

      // R6: empty interval after a busy one gives zero
      run_interval(0, 0, prev, "R6 empty");
      prev = 0;

      // R2: one long high pulse counts once
      pos = 1'b1;
      repeat (12) @(negedge clk);
      pos = 1'b0;
      repeat (4) @(negedge clk);
      close_interval();
      chk("R2 long pulse once", int'(code), int'(K));

      // R7: rise detected on the sync edge belongs to the new interval
      run_interval(2, 1, int'(K), "R7 pre");
      repeat (2) @(negedge clk);
      pos = 1'b1;
      repeat (2) @(negedge clk);
      sync = 1'b1;
      @(negedge clk);
      sync = 1'b0;
      chk("R7 edge excluded from closing interval", int'(code), 0);
      @(negedge clk);
      pos = 1'b0;
      repeat (6) @(negedge clk);
      close_interval();
      chk("R7 edge included in new interval", int'(code), int'(K));

      // R8: saturation on each channel, then recovery
      run_interval(MAXC + 2, 3, int'(K), "R8 pos sat");
      run_interval(1, MAXC + 3, int'(K) * (MAXC - 3), "R8 neg sat");
      run_interval(MAXC, 0, int'(K) * (1 - MAXC), "R8 full no ovf");
      run_interval(2, 2, int'(K) * MAXC, "R8 clears");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule